// File: doc/BRIEF.md
# Fractional-N feedback divider

This block is the programmable feedback divider of a frequency synthesizer. It runs on the output of an external dual-modulus prescaler, which divides the VCO by P or P+1. Two counters set the integer ratio. The main counter counts M prescaler periods per count cycle. The swallow counter drives `mod_ctl` high for the first A of those periods, so the prescaler divides by P+1 there. One count cycle therefore spans N = M·P + A VCO periods. `div_pulse` marks the last prescaler period of every count cycle and goes to the phase detector.

A modulo accumulator gives non-integer ratios. At every count-cycle boundary it adds a numerator and wraps at a selectable modulus of 5, 8, 13 or 20. When it wraps, the swallow load for the cycle that follows is raised by one, so that cycle lasts N+1 VCO periods. Over modulus cycles the mean ratio is N + num/modulus. The accumulator value is brought out so that external logic can scale a spur-compensation pulse from it.

The block has no data stream. All pins are plain control and status signals with no handshake. The configuration inputs are sampled only at count-cycle boundaries, so software may change them at any time. Legal settings are M ≥ 2 and A + 1 < M.

Top module: `fracn_fb_divider`

## Requirements
- R1: `cfg_mod_sel` picks the modulus: 2'b00 gives 5, 2'b01 gives 8, 2'b10 gives 13 and 2'b11 gives 20.
- R2: At each count-cycle boundary the accumulator becomes (acc + effective numerator) mod modulus. `acc_value` shows the accumulator and is always below the active modulus.
- R3: If the addition at a boundary reaches or exceeds the modulus, the cycle that follows has A+1 swallow periods. Only that one cycle is lengthened.
- R4: `mod_ctl` is high for the first A (+1 after a wrap) prescaler periods of a cycle and low at the end of the cycle. A cycle lasts M prescaler periods, which is M·P + A (+1) VCO periods.
- R5: Take any window of modulus consecutive cycles that starts at the second cycle after reset. Its VCO length sums to modulus·N + effective numerator, and the length pattern repeats with period modulus. With M=74, A=4, P=8, numerator 2 and modulus 5, five such cycles total 2982.
- R6: A numerator equal to or above the modulus is clamped to modulus−1. A numerator of 0 gives exactly N in every cycle and leaves the accumulator unchanged.
- R7: M, A, numerator and modulus are sampled only at the boundary edge. A change in the middle of a cycle has no effect on the cycle in progress.
- R8: When the modulus code differs from the one active before a boundary, the accumulator restarts from 0 at that boundary. It then holds the effective numerator, with no wrap.
- R9: In reset all outputs are 0. The first clock edge after reset starts a cycle of length N with the accumulator at 0 and no accumulation. `div_pulse` is high for exactly one clock per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_m | input | M_W | Main counter length M, in prescaler periods |
| cfg_a | input | A_W | Swallow count A |
| cfg_num | input | NUM_W | Fractional numerator |
| cfg_mod_sel | input | 2 | Modulus code (R1) |
| div_pulse | output | 1 | One-clock pulse at the end of each count cycle |
| mod_ctl | output | 1 | Prescaler control: 1 means divide by P+1 |
| acc_value | output | 5 | Current accumulator value |

## Verification
The bench builds the divider with its default widths (M_W=8, A_W=5, NUM_W=5) and models a divide-by-8/9 prescaler arithmetically. The 5-bit numerator puts every code from 0 to 31 within reach against all four modulus codes, including every clamped value. With a short M=10 count cycle, each of the 128 pairs can be followed for 2·modulus+1 cycles. This checks every cycle length, every accumulator step, the window sum and the repetition period. Separate runs cover the 596 + 2/5 case and a change of configuration in the middle of a cycle, including a change of modulus.

// File: rtl/fnd_pkg.sv
package fnd_pkg;
  localparam int ACC_W = 5;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    MOD_5  = 2'b00,
    MOD_8  = 2'b01,
    MOD_13 = 2'b10,
    MOD_20 = 2'b11
  } mod_sel_e;

  function automatic logic [ACC_W-1:0] mod_of(mod_sel_e s);
    case (s)
      MOD_5:   return ACC_W'(5);
      MOD_8:   return ACC_W'(8);
      MOD_13:  return ACC_W'(13);
      default: return ACC_W'(20);
    endcase
  endfunction
endpackage

// File: rtl/fnd_frac_acc.sv
module fnd_frac_acc
  import fnd_pkg::*;
#(
  parameter int NUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             step,
  input  logic [NUM_W-1:0] num_in,
  input  mod_sel_e         sel_in,
  output logic [ACC_W-1:0] acc_q,
  output logic             carry_o
);
  localparam int SUM_W = ((NUM_W > ACC_W) ? NUM_W : ACC_W) + 1;

  mod_sel_e         sel_q;
  logic [SUM_W-1:0] mod_ext, num_ext, num_c, base, sum, nxt;
  logic             chg, ovf;

  // R1: modulus decode; R6: numerator clamp
  always_comb begin
    mod_ext = SUM_W'(mod_of(sel_in));
    num_ext = SUM_W'(num_in);
    num_c   = (num_ext >= mod_ext) ? (mod_ext - 1'b1) : num_ext;
    chg     = (sel_in != sel_q);
    base    = chg ? '0 : SUM_W'(acc_q);     // R8: restart on modulus change
    sum     = base + num_c;
    ovf     = (sum >= mod_ext);
    nxt     = ovf ? (sum - mod_ext) : sum;
  end

  assign carry_o = step & ovf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      sel_q <= MOD_5;
    end else if (restart) begin
      acc_q <= '0;
      sel_q <= sel_in;
    end else if (step) begin
      acc_q <= nxt[ACC_W-1:0];
      sel_q <= sel_in;
    end
  end

  p_acc_below_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < mod_of(sel_q));

  p_zero_num_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && num_in == '0 && !chg) |=> (acc_q == $past(acc_q)));
endmodule

// File: rtl/fnd_div_count.sv
module fnd_div_count #(
  parameter int M_W = 8,
  parameter int A_W = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_in,
  input  logic [A_W-1:0] a_in,
  input  logic           carry_in,
  output logic           wrap_o,
  output logic           mod_ctl_o
);
  localparam int AQ_W = A_W + 1;

  logic [M_W-1:0]  m_q;
  logic [AQ_W-1:0] a_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_q <= '0;
      a_q <= '0;
    end else if (load) begin
      m_q <= m_in - 1'b1;
      a_q <= {1'b0, a_in} + AQ_W'(carry_in);   // R3: one extra swallow
    end else begin
      if (m_q != '0) m_q <= m_q - 1'b1;
      if (a_q != '0) a_q <= a_q - 1'b1;
    end
  end

  assign wrap_o    = (m_q == '0);
  assign mod_ctl_o = (a_q != '0);
endmodule

// File: rtl/fracn_fb_divider.sv
module fracn_fb_divider
  import fnd_pkg::*;
#(
  parameter int M_W   = 8,
  parameter int A_W   = 5,
  parameter int NUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [M_W-1:0]   cfg_m,
  input  logic [A_W-1:0]   cfg_a,
  input  logic [NUM_W-1:0] cfg_num,
  input  logic [1:0]       cfg_mod_sel,
  output logic             div_pulse,
  output logic             mod_ctl,
  output logic [ACC_W-1:0] acc_value
);
  logic primed, wrap, carry, restart, step;

  // R9: first edge after reset only primes the counters
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  assign restart   = wrap & ~primed;
  assign step      = wrap &  primed;
  assign div_pulse = step;

  fnd_frac_acc #(.NUM_W(NUM_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .step    (step),
    .num_in  (cfg_num),
    .sel_in  (mod_sel_e'(cfg_mod_sel)),
    .acc_q   (acc_value),
    .carry_o (carry)
  );

  fnd_div_count #(.M_W(M_W), .A_W(A_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (wrap),
    .m_in      (cfg_m),
    .a_in      (cfg_a),
    .carry_in  (carry),
    .wrap_o    (wrap),
    .mod_ctl_o (mod_ctl)
  );

  p_hold_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && !div_pulse) |=> $stable(acc_value));

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (div_pulse && cfg_m > 1) |=> !div_pulse);
endmodule

// File: tb/sim_fracn_fb_divider.sv
module sim_fracn_fb_divider;
  localparam int P = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_m = 8'd10;
  logic [4:0] cfg_a = 5'd3;
  logic [4:0] cfg_num = '0;
  logic [1:0] cfg_mod_sel = '0;
  logic       div_pulse, mod_ctl;
  logic [4:0] acc_value;

  int total = 0, bad = 0, wd = 0;
  int vco, exp_len, acc_m, prev_sel, ncyc, last_acc;
  bit pending, prime;
  int lens [0:63];

  always #5 clk = ~clk;

  fracn_fb_divider u0 (.*);

  function automatic int modv(int s);
    case (s)
      0: return 5;
      1: return 8;
      2: return 13;
      default: return 20;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (pending) begin
      int md, nc, base, sum, c;
      md = modv(cfg_mod_sel);
      nc = (cfg_num >= md) ? md - 1 : int'(cfg_num);
      if (prime) begin
        acc_m = 0; c = 0; prime = 0;
      end else begin
        base  = (int'(cfg_mod_sel) != prev_sel) ? 0 : acc_m;
        sum   = base + nc;
        c     = (sum >= md) ? 1 : 0;
        acc_m = c ? sum - md : sum;
      end
      prev_sel = cfg_mod_sel;
      exp_len  = cfg_m * P + cfg_a + c;
      pending  = 0;
    end
    vco += P + int'(mod_ctl);
    if (div_pulse) begin
      chk(vco == exp_len, "R4/R3 cycle length", vco, exp_len);
      chk(acc_value == acc_m, "R2 accumulator", acc_value, acc_m);
      chk(mod_ctl == 1'b0, "R4 mod_ctl low at end", mod_ctl, 0);
      if (ncyc < 64) lens[ncyc] = vco;
      last_acc = acc_value;
      ncyc++;
      vco = 0;
      pending = 1;
    end
  endtask

  task automatic restart_dut(int m, int a, int num, int sel);
    rst_n = 1'b0;
    cfg_m = m[7:0]; cfg_a = a[4:0]; cfg_num = num[4:0]; cfg_mod_sel = sel[1:0];
    repeat (3) @(negedge clk);
    chk(div_pulse == 0 && mod_ctl == 0 && acc_value == 0, "R9 reset state",
        int'({div_pulse, mod_ctl, acc_value}), 0);
    rst_n = 1'b1;
    pending = 1; prime = 1; vco = 0; ncyc = 0;
  endtask

  task automatic run_to(int n);
    while (ncyc < n) step();
  endtask

  initial begin
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    // R5 worked case: 596 + 2/5
    restart_dut(74, 4, 2, 0);
    run_to(6);
    begin
      int s = 0;
      for (int k = 1; k <= 5; k++) s += lens[k];
      chk(s == 2982, "R5 five-cycle total", s, 2982);
      chk(lens[0] == 596, "R9 first cycle is N", lens[0], 596);
      chk(lens[3] == 597, "R3 cycle after wrap", lens[3], 597);
      chk(lens[4] == 596, "R3 only one cycle lengthened", lens[4], 596);
    end

    // R1 R5 R6 sweep over every numerator and modulus code, N = 83
    for (int sel = 0; sel < 4; sel++) begin
      for (int num = 0; num < 32; num++) begin
        int md, nc, s, rep;
        md = modv(sel);
        nc = (num >= md) ? md - 1 : num;
        restart_dut(10, 3, num, sel);
        run_to(2 * md + 1);
        s = 0; rep = 1;
        for (int k = 1; k <= md; k++) begin
          s += lens[k];
          if (lens[k] != lens[k + md]) rep = 0;
        end
        chk(s == md * 83 + nc, "R1/R5/R6 window sum", s, md * 83 + nc);
        chk(rep == 1, "R5 repeat period", rep, 1);
        if (num == 0) chk(lens[1] == 83 && lens[md] == 83, "R6 zero numerator", lens[md], 83);
      end
    end

    // R7 R8: mid-cycle change of M, numerator and modulus
    restart_dut(10, 3, 3, 1);
    run_to(3);
    repeat (4) step();
    cfg_m = 8'd12; cfg_num = 5'd5; cfg_mod_sel = 2'b10;
    run_to(4);
    chk(lens[3] == 84, "R7 cycle in progress unchanged", lens[3], 84);
    run_to(5);
    chk(lens[4] == 99, "R7 new M after boundary", lens[4], 99);
    chk(last_acc == 5, "R8 accumulator restart", last_acc, 5);
    run_to(7);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule